// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a flash interface and decides when a program or erase that is already running has ended. It reads a status byte from one fixed location over and over, using a request/acknowledge read port. The block watches whether a chosen status bit (the toggle bit) keeps flipping between reads. When that bit stops changing, the operation has finished. If the bit is still toggling after the device has raised its timeout-error bit, the block writes a reset command and reports failure.

A start pulse latches the polling address. The block then takes reads in pairs. A pair whose toggle bits match ends the poll with success. A pair whose toggle bits differ, with the error bit clear in the newer byte, starts another pair. A differing pair with the error bit set starts one confirming pair. The error bit alone never ends polling, because the toggle bit can stop in the same read in which the error bit appears.

A read budget set at build time bounds the whole poll, so a device that never settles cannot hang the controller. Exhausting the budget ends in the same reset-then-fail path.

Top module: `tbp_poll_ctrl`

## Requirements
- R1: A start pulse while idle raises busy and latches the address; every read and the reset write use that address. A start pulse while busy has no effect on the address, the read count or the outcome.
- R2: A read or write request stays high until the cycle in which ack_i is high. The status byte is taken from rd_data_i in that same cycle.
- R3: If bit TOGGLE_BIT (default 6) is the same in both bytes of a pair, the poll ends with one done pulse and no write.
- R4: If bit TOGGLE_BIT differs within a pair and bit ERR_BIT (default 5) of the later byte is 0, the block issues another pair of reads.
- R5: If bit TOGGLE_BIT differs and bit ERR_BIT of the later byte is 1, the block issues exactly one more pair. If bit TOGGLE_BIT matches in that pair, the poll ends in done.
- R6: If bit TOGGLE_BIT still differs in the confirming pair, the block issues one write request with data RESET_CMD (default 0xF0), holds it until it is acknowledged, and then pulses fail.
- R7: A poll never issues more than MAX_READS reads. When the next pair would exceed that count, the block takes the reset-write-then-fail path instead.
- R8: done_o and fail_o are single-cycle pulses and are never high together. Each appears in the first cycle in which busy_o is low. Read and write requests are never high together.
- R9: After reset, busy_o, done_o, fail_o, rd_req_o and wr_req_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a poll (used only when idle) |
| addr_i | input | AW | Address of the status location |
| ack_i | input | 1 | Acknowledge for the pending read or write |
| rd_data_i | input | DW | Status byte, valid with ack_i on a read |
| rd_req_o | output | 1 | Read request |
| wr_req_o | output | 1 | Write request (reset command) |
| addr_o | output | AW | Address for the request |
| wr_data_o | output | DW | Write data (reset command value) |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |

## Verification
The bench goes after the case where the error bit appears in the same pair in which toggling stops. A design that treats the error bit as final would write a reset and fail where success is expected. The bench also covers the opposite case, where the confirming pair still toggles. A design that skips the recheck there would either take the wrong number of reads or leave out the reset write. The read budget is driven right to its edge, both during looping pairs and just before a recheck, to catch an off-by-one that allows one pair too many or stops one pair short. The bench also varies acknowledge latency and sends a second start in mid-poll, which exposes designs that sample data outside the acknowledge cycle or that relatch the address.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD1,
      ST_RD2,
      ST_JUDGE,
      ST_CHK1,
      ST_CHK2,
      ST_CJUDGE,
      ST_RSTW
   } tbp_state_e;

   function automatic logic is_read_state(tbp_state_e s);
      return (s == ST_RD1) || (s == ST_RD2) || (s == ST_CHK1) || (s == ST_CHK2);
   endfunction

endpackage

// File: rtl/tbp_sample_pair.sv
module tbp_sample_pair (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_i,
   input  logic tog_bit_i,
   input  logic err_bit_i,
   output logic toggled_o,
   output logic err_o
);
   logic older_q;
   logic newer_q;
   logic err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         older_q <= 1'b0;
         newer_q <= 1'b0;
         err_q   <= 1'b0;
      end else if (cap_i) begin
         older_q <= newer_q;
         newer_q <= tog_bit_i;
         err_q   <= err_bit_i;
      end
   end

   assign toggled_o = older_q ^ newer_q;
   assign err_o     = err_q;
endmodule

// File: rtl/tbp_read_budget.sv
module tbp_read_budget #(
   parameter int MAX_READS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic room_o
);
   generate
      if (MAX_READS == 0) begin : g_unbounded
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ clr_i ^ inc_i;
         assign room_o    = 1'b1;
      end else begin : g_bounded
         localparam int CW = $clog2(MAX_READS + 1);
         localparam logic [CW-1:0] LAST_PAIR = CW'(MAX_READS - 2);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clr_i)  cnt_q <= '0;
            else if (inc_i)  cnt_q <= cnt_q + CW'(1);
         end

         assign room_o = (cnt_q <= LAST_PAIR);
      end
   endgenerate
endmodule

// File: rtl/tbp_sequencer.sv
module tbp_sequencer
   import tbp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic ack_i,
   input  logic toggled_i,
   input  logic err_i,
   input  logic room_i,
   output logic accept_o,
   output logic cap_o,
   output logic rd_req_o,
   output logic wr_req_o,
   output logic busy_o,
   output logic done_o,
   output logic fail_o
);
   tbp_state_e st_q, st_d;
   logic done_q, fail_q;
   logic finish_ok;

   always_comb begin
      st_d      = st_q;
      finish_ok = 1'b0;
      unique case (st_q)
         ST_IDLE:   if (start_i) st_d = ST_RD1;
         ST_RD1:    if (ack_i)   st_d = ST_RD2;
         ST_RD2:    if (ack_i)   st_d = ST_JUDGE;
         ST_JUDGE: begin
            if (!toggled_i) begin
               st_d      = ST_IDLE;
               finish_ok = 1'b1;
            end else if (!room_i) st_d = ST_RSTW;
            else if (err_i)       st_d = ST_CHK1;
            else                  st_d = ST_RD1;
         end
         ST_CHK1:   if (ack_i)   st_d = ST_CHK2;
         ST_CHK2:   if (ack_i)   st_d = ST_CJUDGE;
         ST_CJUDGE: begin
            if (!toggled_i) begin
               st_d      = ST_IDLE;
               finish_ok = 1'b1;
            end else st_d = ST_RSTW;
         end
         ST_RSTW:   if (ack_i)   st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         done_q <= 1'b0;
         fail_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= finish_ok;
         fail_q <= (st_q == ST_RSTW) && ack_i;
      end
   end

   assign rd_req_o = is_read_state(st_q);
   assign wr_req_o = (st_q == ST_RSTW);
   assign busy_o   = (st_q != ST_IDLE);
   assign accept_o = (st_q == ST_IDLE) && start_i;
   assign cap_o    = rd_req_o && ack_i;
   assign done_o   = done_q;
   assign fail_o   = fail_q;
endmodule

// File: rtl/tbp_poll_ctrl.sv
module tbp_poll_ctrl #(
   parameter int          AW         = 24,
   parameter int          DW         = 8,
   parameter int          TOGGLE_BIT = 6,
   parameter int          ERR_BIT    = 5,
   parameter int          MAX_READS  = 64,
   parameter logic [7:0]  RESET_CMD  = 8'hF0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] addr_i,
   input  logic          ack_i,
   input  logic [DW-1:0] rd_data_i,
   output logic          rd_req_o,
   output logic          wr_req_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] wr_data_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          fail_o
);
   generate
      if (TOGGLE_BIT >= DW || ERR_BIT >= DW) begin : g_bad_bit
         $error("status bit index outside data width");
      end
      if (TOGGLE_BIT == ERR_BIT) begin : g_same_bit
         $error("toggle and error bits must differ");
      end
      if (MAX_READS != 0 && MAX_READS < 4) begin : g_bad_budget
         $error("read budget must be 0 or at least 4");
      end
      if (DW < 8) begin : g_narrow
         $error("data width must hold the reset command");
      end
   endgenerate

   logic          accept, cap, toggled, err, room;
   logic [AW-1:0] addr_q;
   logic          unused_bits;

   assign unused_bits = ^rd_data_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (accept) addr_q <= addr_i;
   end

   assign addr_o    = addr_q;
   assign wr_data_o = DW'(RESET_CMD);

   tbp_sample_pair u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_i     (cap),
      .tog_bit_i (rd_data_i[TOGGLE_BIT]),
      .err_bit_i (rd_data_i[ERR_BIT]),
      .toggled_o (toggled),
      .err_o     (err)
   );

   tbp_read_budget #(.MAX_READS(MAX_READS)) u_budget (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (accept),
      .inc_i  (cap),
      .room_o (room)
   );

   tbp_sequencer u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .ack_i     (ack_i),
      .toggled_i (toggled),
      .err_i     (err),
      .room_i    (room),
      .accept_o  (accept),
      .cap_o     (cap),
      .rd_req_o  (rd_req_o),
      .wr_req_o  (wr_req_o),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .fail_o    (fail_o)
   );
endmodule

// File: rtl/tbp_poll_ctrl_chk.sv
module tbp_poll_ctrl_chk #(
   parameter int          AW        = 24,
   parameter int          DW        = 8,
   parameter int          MAX_READS = 64,
   parameter logic [7:0]  RESET_CMD = 8'hF0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          ack_i,
   input logic          rd_req_o,
   input logic          wr_req_o,
   input logic [AW-1:0] addr_o,
   input logic [DW-1:0] wr_data_o,
   input logic          busy_o,
   input logic          done_o,
   input logic          fail_o
);
   p_idle_reset_r9: assert property (@(posedge clk) !rst_n |-> !busy_o && !rd_req_o && !wr_req_o);

   p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && !ack_i |=> rd_req_o);
   p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o && !ack_i |=> wr_req_o);
   p_wr_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |-> wr_data_o == DW'(RESET_CMD));
   p_fail_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> $past(wr_req_o && ack_i));
   p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> $stable(addr_o));
   p_excl_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_req_o, wr_req_o}));
   p_excl_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, fail_o}));
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_fail_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |=> !fail_o);
   p_end_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o || fail_o |-> !busy_o && $past(busy_o));

   generate
      if (MAX_READS > 0) begin : g_budget
         localparam int CW = $clog2(MAX_READS + 2);
         logic [CW-1:0] reads_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   reads_q <= '0;
            else if (start_i && !busy_o)  reads_q <= '0;
            else if (rd_req_o && ack_i)   reads_q <= reads_q + CW'(1);
         end
         p_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
            reads_q <= CW'(MAX_READS));
      end
   endgenerate
endmodule

bind tbp_poll_ctrl tbp_poll_ctrl_chk #(
   .AW(AW), .DW(DW), .MAX_READS(MAX_READS), .RESET_CMD(RESET_CMD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i),
   .rd_req_o(rd_req_o), .wr_req_o(wr_req_o), .addr_o(addr_o),
   .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
);

// File: tb/sim_tbp_poll_ctrl.sv
`timescale 1ns/1ps
module sim_tbp_poll_ctrl;
   localparam int AW = 16;
   localparam int DW = 8;
   localparam int MAXR = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          ack_i = 1'b0;
   logic [DW-1:0] rd_data_i = '0;
   logic          rd_req_o, wr_req_o, busy_o, done_o, fail_o;
   logic [AW-1:0] addr_o;
   logic [DW-1:0] wr_data_o;

   always #2.5 clk = ~clk;

   tbp_poll_ctrl #(.AW(AW), .DW(DW), .MAX_READS(MAXR)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
      .ack_i(ack_i), .rd_data_i(rd_data_i), .rd_req_o(rd_req_o),
      .wr_req_o(wr_req_o), .addr_o(addr_o), .wr_data_o(wr_data_o),
      .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
   );

   int checks = 0, errs = 0, cycles = 0;
   logic [DW-1:0] script [0:31];
   int idx = 0, lat = 0, dly = 0;
   int n_rd = 0, n_wr = 0, n_done = 0, n_fail = 0;
   int bad_addr = 0, bad_wdata = 0, bad_pulse = 0, bad_excl = 0;
   logic [AW-1:0] exp_addr = '0;
   logic prev_done = 1'b0, prev_fail = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // device model and monitor, both at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (done_o && fail_o) bad_excl++;
         if (rd_req_o && wr_req_o) bad_excl++;
         if ((done_o && prev_done) || (fail_o && prev_fail)) bad_pulse++;
         if ((done_o || fail_o) && busy_o) bad_pulse++;
         if (done_o) n_done++;
         if (fail_o) n_fail++;
         prev_done = done_o;
         prev_fail = fail_o;
         if (ack_i) begin
            ack_i = 1'b0;
            rd_data_i = 8'hAA;
         end else if (rd_req_o || wr_req_o) begin
            if (dly >= lat) begin
               dly = 0;
               ack_i = 1'b1;
               if (addr_o != exp_addr) bad_addr++;
               if (rd_req_o) begin
                  rd_data_i = script[idx];
                  if (idx < 31) idx++;
                  n_rd++;
               end else begin
                  if (wr_data_o != 8'hF0) bad_wdata++;
                  n_wr++;
               end
            end else dly++;
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errs++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
         $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
         $finish;
      end
   end

   task automatic clear_stats(input int l);
      idx = 0; lat = l; dly = 0;
      n_rd = 0; n_wr = 0; n_done = 0; n_fail = 0;
      bad_addr = 0; bad_wdata = 0; bad_pulse = 0; bad_excl = 0;
      for (int i = 0; i < 32; i++) script[i] = 8'h00;
   endtask

   task automatic kick(input logic [AW-1:0] a);
      @(negedge clk);
      start_i = 1'b1; addr_i = a;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_end;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (n_done + n_fail > 0) break;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic expect_out(input string req, input int rd, input int wr,
                             input int dn, input int fl);
      chk(n_rd == rd, req, "read count", n_rd, rd);
      chk(n_wr == wr, req, "write count", n_wr, wr);
      chk(n_done == dn, req, "done pulses", n_done, dn);
      chk(n_fail == fl, req, "fail pulses", n_fail, fl);
      chk(bad_addr == 0, "R1", "address mismatches", bad_addr, 0);
      chk(bad_pulse == 0 && bad_excl == 0, "R8", "pulse/exclusion errors",
          bad_pulse + bad_excl, 0);
      chk(!busy_o, req, "busy after end", busy_o, 0);
   endtask

   task automatic t_reset;
      chk(!busy_o && !done_o && !fail_o, "R9", "busy/done/fail in reset",
          {busy_o, done_o, fail_o}, 0);
      chk(!rd_req_o && !wr_req_o, "R9", "requests in reset",
          {rd_req_o, wr_req_o}, 0);
   endtask

   task automatic t_stable_r3(input int l);
      clear_stats(l);
      script[0] = 8'h40; script[1] = 8'h40;
      exp_addr = 16'h1234;
      kick(16'h1234);
      wait_end();
      expect_out("R3", 2, 0, 1, 0);
   endtask

   task automatic t_loop_r4;
      clear_stats(1);
      script[0] = 8'h00; script[1] = 8'h40;
      script[2] = 8'h40; script[3] = 8'h00;
      script[4] = 8'h00; script[5] = 8'h00;
      exp_addr = 16'h0101;
      kick(16'h0101);
      wait_end();
      expect_out("R4", 6, 0, 1, 0);
   endtask

   task automatic t_recover_r5;
      clear_stats(0);
      script[0] = 8'h00; script[1] = 8'h60;
      script[2] = 8'h20; script[3] = 8'h20;
      exp_addr = 16'h0F0F;
      kick(16'h0F0F);
      wait_end();
      expect_out("R5", 4, 0, 1, 0);
   endtask

   task automatic t_fail_r6;
      clear_stats(2);
      script[0] = 8'h00; script[1] = 8'h60;
      script[2] = 8'h20; script[3] = 8'h60;
      exp_addr = 16'h5555;
      kick(16'h5555);
      wait_end();
      expect_out("R6", 4, 1, 0, 1);
      chk(bad_wdata == 0, "R6", "reset command data errors", bad_wdata, 0);
   endtask

   task automatic t_budget_loop_r7;
      clear_stats(0);
      for (int i = 0; i < 32; i++) script[i] = (i % 2) ? 8'h40 : 8'h00;
      exp_addr = 16'h7000;
      kick(16'h7000);
      wait_end();
      expect_out("R7", MAXR, 1, 0, 1);
   endtask

   task automatic t_budget_chk_r7;
      clear_stats(0);
      for (int i = 0; i < 32; i++) script[i] = (i % 2) ? 8'h40 : 8'h00;
      script[7] = 8'h60;
      exp_addr = 16'h7100;
      kick(16'h7100);
      wait_end();
      expect_out("R7", MAXR, 1, 0, 1);
   endtask

   task automatic t_busy_start_r1;
      clear_stats(4);
      script[0] = 8'h00; script[1] = 8'h40;
      script[2] = 8'h44; script[3] = 8'h44;
      exp_addr = 16'hBEEF;
      kick(16'hBEEF);
      repeat (3) @(negedge clk);
      chk(busy_o, "R1", "busy while polling", busy_o, 1);
      kick(16'h0BAD);
      wait_end();
      expect_out("R1", 4, 0, 1, 0);
      chk(addr_o == 16'hBEEF, "R1", "held address", addr_o, 16'hBEEF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_stable_r3(0);
      t_stable_r3(3);   // R2: data sampled only in the acknowledge cycle
      t_loop_r4();
      t_recover_r5();
      t_fail_r6();
      t_budget_loop_r7();
      t_budget_chk_r7();
      t_busy_start_r1();
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
   end
endmodule